// File: doc/BRIEF.md
# Timestamp and Timer Pulse Unit

This block is the time base of a packet-processing subsystem. A single-cycle enable marks each tick of the crystal oscillator. The block counts these ticks in a free-running 56-bit timestamp counter. It derives three coarse timestamps from that counter: a logging stamp, a tag stamp and a translation-table stamp. Each coarse stamp is the counter moved right by its own programmable amount. The logging stamp can instead show a legacy count of millisecond ticks.

The same oscillator ticks also feed a common divider. When the divider is enabled, it produces one common tick for every programmed value plus one oscillator ticks. With the default value of 191 on a 19.2 MHz oscillator, the common tick has a 10 us period. A set of pulse generators counts common ticks. Each generator emits a one-cycle timer pulse at the period chosen by its own granularity code. Timer consumers downstream use these pulses.

Software configures the unit through a simple write port. To change the divider, software first clears its enable, then writes the new value, then sets the enable again.

Top module: `tstamp_pulse_unit`

## Requirements
- R1: After reset, all three stamps and all pulses are zero. The tag and translation-table shifts reset to 14 and 24, the logging shift resets to 14, and the logging select, divider value, divider enable and granularity codes reset to zero.
- R2: The timestamp counter increments by one in each cycle where `xo_tick` is high, holds its value otherwise, and wraps modulo 2^56.
- R3: The write at address 0 sets three shifts and the logging select. Bits [13:8] are the tag shift and bits [21:16] are the translation-table shift. Bits [5:0] are the logging shift and bit 7 is the logging select. The tag stamp always equals the counter shifted right by the tag shift, and the translation-table stamp equals the counter shifted right by its shift.
- R4: While the logging select is 1, the logging stamp is the counter shifted right by the logging shift. While it is 0, the logging stamp is the number of cycles since reset in which `msec_tick` was high.
- R5: The write at address 1 sets the divider value in bits [15:0] and the divider enable in bit 31. While the divider is enabled, one common tick occurs for every value+1 oscillator ticks.
- R6: While the divider enable is 0, no pulse occurs and the divider and generator counts return to zero. After the enable is set again, the first pulse of each generator arrives exactly one full period of oscillator ticks later.
- R7: A write to address 1 while the stored enable is 1 leaves the divider value unchanged, while its enable bit still takes effect.
- R8: The write at address 2 sets generator i's granularity code in bits [4i+2:4i]. The codes map to periods in common ticks as follows: 0 gives 1, 1 gives 2, 2 gives 5, 3 gives 10, 4 gives 100, 5 gives 1000, 6 gives 10000 and 7 gives 100000. Generator i pulses once every (value+1) times that many oscillator ticks.
- R9: Each pulse is high for one clock cycle, in the cycle after the oscillator tick that completes its period. It repeats in the following cycle only when the next period also completes on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xo_tick | input | 1 | One-cycle enable per oscillator tick |
| msec_tick | input | 1 | One-cycle enable per legacy millisecond |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration write address |
| wr_data | input | 32 | Configuration write data |
| ts_log | output | 56 | Logging timestamp |
| ts_tag | output | 56 | Tag timestamp |
| ts_nat | output | 56 | Translation-table timestamp |
| pulse | output | 3 | One-cycle timer pulses, one per generator |

## Verification
On every cycle, the embedded assertions check four properties. The counter steps by one per oscillator tick and holds otherwise. The divider count never exceeds the programmed value while enabled. The divider value is frozen whenever the enable was set. A pulse only follows a common tick, and only while the divider was enabled. Other behaviours can only be shown by the bench's scenarios, which compare every output each cycle against an independent model. These include the exact pulse spacing for each granularity code, the reset defaults of the shifts, the switch of the logging stamp to the legacy millisecond count, and the full-period delay of the first pulse after re-enable.

// File: rtl/tpu_pkg.sv
package tpu_pkg;
  localparam int GRAN_W   = 3;
  localparam int PG_CNT_W = 17;
  localparam int ADDR_TS   = 0;
  localparam int ADDR_DIV  = 1;
  localparam int ADDR_GRAN = 2;
  localparam int DIV_EN_BIT = 31;
  localparam int LOG_SEL_BIT = 7;

  function automatic logic [PG_CNT_W-1:0] gran_period(input logic [GRAN_W-1:0] code);
    logic [PG_CNT_W-1:0] p;
    case (code)
      3'd0:    p = PG_CNT_W'(1);
      3'd1:    p = PG_CNT_W'(2);
      3'd2:    p = PG_CNT_W'(5);
      3'd3:    p = PG_CNT_W'(10);
      3'd4:    p = PG_CNT_W'(100);
      3'd5:    p = PG_CNT_W'(1000);
      3'd6:    p = PG_CNT_W'(10000);
      default: p = PG_CNT_W'(100000);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/tpu_cfg_regs.sv
module tpu_cfg_regs
  import tpu_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int SHIFT_W = 6,
  parameter int DIV_W   = 16,
  parameter int NUM_PG  = 3,
  parameter logic [SHIFT_W-1:0] LOG_SH_RST = 6'd14,
  parameter logic [SHIFT_W-1:0] TAG_SH_RST = 6'd14,
  parameter logic [SHIFT_W-1:0] NAT_SH_RST = 6'd24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [31:0]                    wr_data,
  output logic [SHIFT_W-1:0]             log_sh,
  output logic                           log_sel,
  output logic [SHIFT_W-1:0]             tag_sh,
  output logic [SHIFT_W-1:0]             nat_sh,
  output logic [DIV_W-1:0]               div_val,
  output logic                           div_en,
  output logic [NUM_PG-1:0][GRAN_W-1:0]  gran
);
  logic [SHIFT_W-1:0]            log_sh_q, log_sh_n, tag_sh_q, tag_sh_n, nat_sh_q, nat_sh_n;
  logic                          log_sel_q, log_sel_n, div_en_q, div_en_n;
  logic [DIV_W-1:0]              div_val_q, div_val_n;
  logic [NUM_PG-1:0][GRAN_W-1:0] gran_q, gran_n;
  logic                          hit_ts, hit_div, hit_gran;

  assign hit_ts   = wr_en && (wr_addr == ADDR_W'(ADDR_TS));
  assign hit_div  = wr_en && (wr_addr == ADDR_W'(ADDR_DIV));
  assign hit_gran = wr_en && (wr_addr == ADDR_W'(ADDR_GRAN));

  always_comb begin
    log_sh_n  = log_sh_q;
    tag_sh_n  = tag_sh_q;
    nat_sh_n  = nat_sh_q;
    log_sel_n = log_sel_q;
    div_val_n = div_val_q;
    div_en_n  = div_en_q;
    gran_n    = gran_q;
    if (hit_ts) begin
      log_sh_n  = wr_data[SHIFT_W-1:0];
      log_sel_n = wr_data[LOG_SEL_BIT];
      tag_sh_n  = wr_data[8 +: SHIFT_W];
      nat_sh_n  = wr_data[16 +: SHIFT_W];
    end
    if (hit_div) begin
      div_en_n = wr_data[DIV_EN_BIT];
      if (!div_en_q) div_val_n = wr_data[DIV_W-1:0];
    end
    if (hit_gran) begin
      for (int i = 0; i < NUM_PG; i++) gran_n[i] = wr_data[4*i +: GRAN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_sh_q  <= LOG_SH_RST;
      tag_sh_q  <= TAG_SH_RST;
      nat_sh_q  <= NAT_SH_RST;
      log_sel_q <= 1'b0;
      div_val_q <= '0;
      div_en_q  <= 1'b0;
      gran_q    <= '0;
    end else begin
      log_sh_q  <= log_sh_n;
      tag_sh_q  <= tag_sh_n;
      nat_sh_q  <= nat_sh_n;
      log_sel_q <= log_sel_n;
      div_val_q <= div_val_n;
      div_en_q  <= div_en_n;
      gran_q    <= gran_n;
    end
  end

  assign log_sh  = log_sh_q;
  assign tag_sh  = tag_sh_q;
  assign nat_sh  = nat_sh_q;
  assign log_sel = log_sel_q;
  assign div_val = div_val_q;
  assign div_en  = div_en_q;
  assign gran    = gran_q;

  // R7
  div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_en_q) |-> (div_val_q == $past(div_val_q)));
endmodule

// File: rtl/tpu_tstamp.sv
module tpu_tstamp #(
  parameter int TS_W    = 56,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xo_tick,
  input  logic               msec_tick,
  input  logic [SHIFT_W-1:0] log_sh,
  input  logic               log_sel,
  input  logic [SHIFT_W-1:0] tag_sh,
  input  logic [SHIFT_W-1:0] nat_sh,
  output logic [TS_W-1:0]    ts_log,
  output logic [TS_W-1:0]    ts_tag,
  output logic [TS_W-1:0]    ts_nat
);
  logic [TS_W-1:0] cnt_q, cnt_n, leg_q, leg_n;

  always_comb begin
    cnt_n = cnt_q;
    leg_n = leg_q;
    if (xo_tick)   cnt_n = cnt_q + 1'b1;
    if (msec_tick) leg_n = leg_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      leg_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      leg_q <= leg_n;
    end
  end

  assign ts_log = log_sel ? (cnt_q >> log_sh) : leg_q;
  assign ts_tag = cnt_q >> tag_sh;
  assign ts_nat = cnt_q >> nat_sh;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xo_tick |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xo_tick |=> $stable(cnt_q));
endmodule

// File: rtl/tpu_xo_divider.sv
module tpu_xo_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xo_tick,
  input  logic             div_en,
  input  logic [DIV_W-1:0] div_val,
  output logic             com_tick
);
  logic [DIV_W-1:0] div_cnt_q, div_cnt_n;
  logic             at_end;

  assign at_end   = (div_cnt_q == div_val);
  assign com_tick = div_en && xo_tick && at_end;

  always_comb begin
    div_cnt_n = div_cnt_q;
    if (!div_en)      div_cnt_n = '0;
    else if (xo_tick) div_cnt_n = at_end ? '0 : div_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt_q <= '0;
    else        div_cnt_q <= div_cnt_n;
  end

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |-> (div_cnt_q <= div_val));
endmodule

// File: rtl/tpu_pulse_gen.sv
module tpu_pulse_gen
  import tpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick_in,
  input  logic [GRAN_W-1:0] gran,
  output logic              pulse
);
  logic [PG_CNT_W-1:0] cnt_q, cnt_n, period;
  logic                pulse_q, pulse_n, last;

  assign period = gran_period(gran);
  assign last   = (cnt_q >= period - 1'b1);

  always_comb begin
    cnt_n   = cnt_q;
    pulse_n = 1'b0;
    if (clr) begin
      cnt_n = '0;
    end else if (tick_in) begin
      cnt_n   = last ? '0 : cnt_q + 1'b1;
      pulse_n = last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      pulse_q <= pulse_n;
    end
  end

  assign pulse = pulse_q;

  // R9
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(tick_in));
endmodule

// File: rtl/tstamp_pulse_unit.sv
module tstamp_pulse_unit
  import tpu_pkg::*;
#(
  parameter int TS_W    = 56,
  parameter int SHIFT_W = 6,
  parameter int DIV_W   = 16,
  parameter int NUM_PG  = 3,
  parameter int ADDR_W  = 4,
  parameter logic [SHIFT_W-1:0] LOG_SH_RST = 6'd14,
  parameter logic [SHIFT_W-1:0] TAG_SH_RST = 6'd14,
  parameter logic [SHIFT_W-1:0] NAT_SH_RST = 6'd24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xo_tick,
  input  logic              msec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [TS_W-1:0]   ts_log,
  output logic [TS_W-1:0]   ts_tag,
  output logic [TS_W-1:0]   ts_nat,
  output logic [NUM_PG-1:0] pulse
);
  logic [SHIFT_W-1:0]            log_sh, tag_sh, nat_sh;
  logic                          log_sel, div_en, com_tick;
  logic [DIV_W-1:0]              div_val;
  logic [NUM_PG-1:0][GRAN_W-1:0] gran;

  tpu_cfg_regs #(
    .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .DIV_W(DIV_W), .NUM_PG(NUM_PG),
    .LOG_SH_RST(LOG_SH_RST), .TAG_SH_RST(TAG_SH_RST), .NAT_SH_RST(NAT_SH_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .log_sh(log_sh), .log_sel(log_sel), .tag_sh(tag_sh), .nat_sh(nat_sh),
    .div_val(div_val), .div_en(div_en), .gran(gran)
  );

  tpu_tstamp #(.TS_W(TS_W), .SHIFT_W(SHIFT_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .xo_tick(xo_tick), .msec_tick(msec_tick),
    .log_sh(log_sh), .log_sel(log_sel), .tag_sh(tag_sh), .nat_sh(nat_sh),
    .ts_log(ts_log), .ts_tag(ts_tag), .ts_nat(ts_nat)
  );

  tpu_xo_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .xo_tick(xo_tick), .div_en(div_en),
    .div_val(div_val), .com_tick(com_tick)
  );

  generate
    for (genvar g = 0; g < NUM_PG; g++) begin : g_pg
      tpu_pulse_gen u_pg (
        .clk(clk), .rst_n(rst_n), .clr(!div_en), .tick_in(com_tick),
        .gran(gran[g]), .pulse(pulse[g])
      );
    end
  endgenerate

  // R6
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |-> $past(div_en));
endmodule

// File: tb/tb_tstamp_pulse_unit.sv
`timescale 1ns/1ps
module tb_tstamp_pulse_unit;
  localparam int TS_W = 56;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xo_tick = 1'b0, msec_tick = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [TS_W-1:0] ts_log, ts_tag, ts_nat;
  logic [2:0]  pulse;

  int checks = 0, errors = 0;
  bit done = 0, live = 0;
  string req_ts = "R1", req_p = "R1";

  always #4 clk = ~clk;

  tstamp_pulse_unit dut (
    .clk(clk), .rst_n(rst_n), .xo_tick(xo_tick), .msec_tick(msec_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ts_log(ts_log), .ts_tag(ts_tag), .ts_nat(ts_nat), .pulse(pulse)
  );

  // reference model, built from the requirements
  logic [TS_W-1:0] m_cnt, m_leg;
  int unsigned m_lsh, m_tsh, m_nsh, m_div;
  bit m_sel, m_en;
  int unsigned m_gran [3];
  longint unsigned m_since;
  bit [2:0] exp_p;

  function automatic longint unsigned period_of(int unsigned code);
    longint unsigned tbl [8] = '{1, 2, 5, 10, 100, 1000, 10000, 100000};
    return tbl[code & 7];
  endfunction

  function automatic logic [TS_W-1:0] shr(logic [TS_W-1:0] v, int unsigned s);
    return (s >= TS_W) ? '0 : (v >> s);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_leg = '0; m_lsh = 14; m_tsh = 14; m_nsh = 24; m_sel = 0;
      m_div = 0; m_en = 0; m_since = 0; exp_p = '0;
      for (int i = 0; i < 3; i++) m_gran[i] = 0;
    end else begin
      exp_p = '0;
      if (m_en && xo_tick) begin
        m_since++;
        for (int i = 0; i < 3; i++)
          exp_p[i] = (m_since % ((longint'(m_div) + 1) * period_of(m_gran[i]))) == 0;
      end
      if (xo_tick) m_cnt = m_cnt + 1'b1;
      if (msec_tick) m_leg = m_leg + 1'b1;
      if (wr_en) begin
        if (wr_addr == 4'd0) begin
          m_lsh = wr_data[5:0]; m_sel = wr_data[7];
          m_tsh = wr_data[13:8]; m_nsh = wr_data[21:16];
        end else if (wr_addr == 4'd1) begin
          if (!m_en) m_div = wr_data[15:0];
          m_en = wr_data[31];
        end else if (wr_addr == 4'd2) begin
          for (int i = 0; i < 3; i++) m_gran[i] = (wr_data >> (4*i)) & 7;
        end
      end
      if (!m_en) m_since = 0;
    end
  end

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && live && !done) begin
      chk(req_ts, "ts_tag", ts_tag, shr(m_cnt, m_tsh));
      chk(req_ts, "ts_nat", ts_nat, shr(m_cnt, m_nsh));
      chk(m_sel ? req_ts : "R4", "ts_log", ts_log, m_sel ? shr(m_cnt, m_lsh) : m_leg);
      chk(req_p, "pulse", pulse, exp_p);
    end
  end

  task automatic cyc(bit xo, bit ms);
    @(negedge clk);
    xo_tick = xo; msec_tick = ms; wr_en = 0;
  endtask

  task automatic wr(int unsigned a, logic [31:0] d);
    @(negedge clk);
    xo_tick = 0; msec_tick = 0; wr_en = 1; wr_addr = 4'(a); wr_data = d;
  endtask

  task automatic run(int n, int xo_pct);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < xo_pct, ($urandom % 4) == 0);
  endtask

  task automatic set_div(int unsigned v, logic [31:0] grans);
    wr(1, 32'h0);
    wr(2, grans);
    wr(1, 32'h8000_0000 | v);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R1: outputs during and just after reset
    chk("R1", "ts_log", ts_log, 0); chk("R1", "ts_tag", ts_tag, 0);
    chk("R1", "ts_nat", ts_nat, 0); chk("R1", "pulse", pulse, 0);
    rst_n = 1'b1;
    live = 1;
    // R1: default shifts observed as the counter passes 2^14
    run(16400, 100);
    chk("R1", "ts_tag default shift", ts_tag, 1);
    // R2: unshifted counter, random ticks
    req_ts = "R2"; req_p = "R2";
    wr(0, 32'h0000_0080);
    run(120, 50);
    // R3: random small shifts and select
    req_ts = "R3"; req_p = "R3";
    for (int k = 0; k < 6; k++) begin
      wr(0, ($urandom % 7) | (($urandom % 2) << 7) | (($urandom % 7) << 8) | (($urandom % 7) << 16));
      run(60, 70);
    end
    // R4: legacy millisecond count on the logging stamp
    req_ts = "R4"; req_p = "R4";
    wr(0, 32'h0000_0003);
    run(200, 60);
    // R5: 192-to-1 divide and smaller divides
    req_ts = "R3"; req_p = "R5";
    set_div(191, 32'h0000_0210);
    run(2100, 100);
    set_div(3, 32'h0000_0210);
    run(600, 40);
    // R8: every code up to 5 on all generators, then 6 and 7
    req_p = "R8";
    for (int g = 0; g < 6; g++) begin
      set_div(1, 32'(g | (g << 4) | (g << 8)));
      run(2 * 2 * int'(period_of(g)) + 20, 100);
    end
    set_div(0, 32'h0000_0776);
    run(10050, 100);
    // R6: disable mid-period, then first pulse a full period after re-enable
    req_p = "R6";
    set_div(4, 32'h0000_0103);
    run(37, 100);
    wr(1, 32'h0000_0000);
    run(300, 100);
    wr(1, 32'h8000_0004);
    run(400, 100);
    // R7: value writes while enabled are ignored
    req_p = "R7";
    wr(1, 32'h8000_0009);
    run(400, 100);
    wr(1, 32'h8000_0000);
    run(200, 70);
    // R9: single-cycle pulses, including back-to-back at the fastest rate
    req_p = "R9";
    set_div(0, 32'h0000_0210);
    run(300, 50);
    run(40, 100);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule